// File: doc/BRIEF.md
# Paired-Word 17-Bit Parcel Unpacker

This block takes variable-length code packed into aligned pairs of 32-bit words and turns it back into whole instructions. Each pair holds three 17-bit parcels, and each parcel has a start flag. The first word carries one full parcel and the upper part of a parcel that crosses into the second word. The second word carries the rest of that crossing parcel and one more full parcel. Each word begins with a fixed prefix, and the block drops any pair whose prefix is wrong.

The block opens a new instruction at every parcel whose start flag is set. It appends the following unflagged parcels to that instruction, and this continues across pair boundaries. An instruction is handed out on a valid/ready port. The port gives a parcel count and a left-aligned payload, plus a flag that marks instructions cut short at the parcel limit. A flush request closes the instruction that is still open once no pair is left to unpack. Parcels are consumed one per cycle, so a pair takes three cycles when the output is not stalled.

Top module: `parcel_pair_unpacker`

## Requirements
- R1: Word 0 must have bits [31:27] = 11110. Its bit 26 is the start flag of parcel A, bit 25 is the start flag of parcel B, bits [24:8] are parcel A, and bits [7:0] are the upper 8 bits of parcel B. Word 1 must have bits [31:27] = 11111. Its bit 26 is the start flag of parcel C, bits [25:17] are the lower 9 bits of parcel B, and bits [16:0] are parcel C.
- R2: Parcels are consumed in the order A, B, C. In the output payload, the first parcel of an instruction occupies the highest 17 bits ([101:85] at default size) and later parcels follow downward. Unused lower parcel slots read zero.
- R3: A parcel with its start flag set opens a new instruction. An instruction that is still open at that point is emitted, with the count of parcels it holds.
- R4: An instruction that is open at the end of a pair continues with the unflagged parcels of the following pairs.
- R5: While flush_i is high and no pair is waiting to be unpacked, an open instruction is emitted. Flush has no effect when no instruction is open.
- R6: An unflagged parcel that arrives when no instruction is open is discarded.
- R7: An instruction that reaches MAX_PARCELS (6) parcels takes no further parcels. Any further unflagged parcels are discarded, and the instruction is emitted with count 6 and insn_trunc_o = 1. Otherwise insn_trunc_o = 0.
- R8: A pair that fails either prefix check is consumed and dropped and changes no instruction. It sets fmt_err_o, which stays high until reset.
- R9: While insn_valid_o is high and insn_ready_i is low, insn_valid_o, the count, the payload and the truncation flag hold steady.
- R10: After reset, insn_valid_o = 0, pair_ready_o = 1 and fmt_err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pair_valid_i | input | 1 | Word pair offered |
| pair_ready_o | output | 1 | Pair buffer empty, pair accepted this cycle if offered |
| word0_i | input | 32 | First word of the pair |
| word1_i | input | 32 | Second word of the pair |
| flush_i | input | 1 | Close the open instruction once idle |
| insn_valid_o | output | 1 | Instruction available |
| insn_ready_i | input | 1 | Consumer takes the instruction |
| insn_count_o | output | 3 | Parcels in the instruction, 1 to 6 |
| insn_payload_o | output | 102 | Parcels, first one in the top bits |
| insn_trunc_o | output | 1 | Instruction exceeded the parcel limit |
| fmt_err_o | output | 1 | Sticky prefix-error flag |

## Verification
The assertions assume that the consumer keeps the ready/valid contract. They also assume that a pair handshake happens only when pair_ready_o is high, so a rejected pair can only ever land in an empty buffer. The stimulus offers pairs only through a handshake task that waits for ready. It raises flush only after the last pair of a group has been handed over, so flush never races with unpacking. Random pairs mix correct and broken prefixes, and random start flags produce lengths from orphan parcels up to overlong instructions.

// File: rtl/pup_pkg.sv
package pup_pkg;
  localparam int WORD_W   = 32;
  localparam int PARCEL_W = 17;
  localparam int NPAIR    = 3;
  localparam int HI_W     = 8;
  localparam int LO_W     = PARCEL_W - HI_W;
  localparam logic [4:0] PFX_W0 = 5'b11110;
  localparam logic [4:0] PFX_W1 = 5'b11111;
  typedef logic [PARCEL_W-1:0] parcel_t;
endpackage

// File: rtl/pair_splitter.sv
module pair_splitter
  import pup_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  output parcel_t           parcel_o [NPAIR],
  output logic [NPAIR-1:0]  start_o,
  output logic              ok_o
);
  localparam int P0_LO = HI_W;
  localparam int SB_W0 = WORD_W - 6;
  localparam int SB_W1 = WORD_W - 6;

  always_comb begin
    ok_o        = (w0_i[WORD_W-1 -: 5] == PFX_W0) && (w1_i[WORD_W-1 -: 5] == PFX_W1);
    start_o[0]  = w0_i[SB_W0];
    start_o[1]  = w0_i[SB_W0-1];
    start_o[2]  = w1_i[SB_W1];
    parcel_o[0] = w0_i[P0_LO +: PARCEL_W];
    parcel_o[1] = {w0_i[HI_W-1:0], w1_i[PARCEL_W +: LO_W]};
    parcel_o[2] = w1_i[PARCEL_W-1:0];
  end
endmodule

// File: rtl/parcel_accum.sv
module parcel_accum
  import pup_pkg::*;
#(
  parameter  int MAX_PARCELS = 6,
  localparam int CW = $clog2(MAX_PARCELS + 1),
  localparam int DW = MAX_PARCELS * PARCEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_vld_i,
  input  parcel_t       parcel_i,
  input  logic          start_i,
  output logic          step_ack_o,
  input  logic          flush_req_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [CW-1:0] out_cnt_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_trunc_o
);
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          trunc_q;
  logic          out_free, need_emit, flush_fire, emit, is_open, full;
  logic [DW-1:0] first_data, app_data;

  always_comb begin
    is_open    = cnt_q != '0;
    full       = cnt_q >= CW'(MAX_PARCELS);
    out_free   = !out_valid_o || out_ready_i;
    need_emit  = step_vld_i && start_i && is_open;
    step_ack_o = step_vld_i && (!need_emit || out_free);
    flush_fire = flush_req_i && !step_vld_i && is_open && out_free;
    emit       = (step_ack_o && need_emit) || flush_fire;
    first_data = {parcel_i, {(DW-PARCEL_W){1'b0}}};
    app_data   = data_q | (first_data >> (PARCEL_W * int'(cnt_q)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      data_q  <= '0;
      trunc_q <= 1'b0;
    end else if (flush_fire) begin
      cnt_q   <= '0;
      data_q  <= '0;
      trunc_q <= 1'b0;
    end else if (step_ack_o) begin
      if (start_i) begin
        cnt_q   <= CW'(1);
        data_q  <= first_data;
        trunc_q <= 1'b0;
      end else if (is_open) begin
        if (full) trunc_q <= 1'b1;
        else begin
          cnt_q  <= cnt_q + CW'(1);
          data_q <= app_data;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_cnt_o   <= '0;
      out_data_o  <= '0;
      out_trunc_o <= 1'b0;
    end else if (emit) begin
      out_valid_o <= 1'b1;
      out_cnt_o   <= cnt_q;
      out_data_o  <= data_q;
      out_trunc_o <= trunc_q;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_cnt_o) && $stable(out_trunc_o)); // R9
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_cnt_o != '0) && (out_cnt_o <= CW'(MAX_PARCELS))); // R3
  AST_TRUNC_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_trunc_o |-> out_cnt_o == CW'(MAX_PARCELS)); // R7
  AST_ACC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_PARCELS)); // R7
endmodule

// File: rtl/parcel_pair_unpacker.sv
module parcel_pair_unpacker
  import pup_pkg::*;
#(
  parameter  int MAX_PARCELS = 6,
  localparam int CW = $clog2(MAX_PARCELS + 1),
  localparam int DW = MAX_PARCELS * PARCEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_valid_i,
  output logic              pair_ready_o,
  input  logic [WORD_W-1:0] word0_i,
  input  logic [WORD_W-1:0] word1_i,
  input  logic              flush_i,
  output logic              insn_valid_o,
  input  logic              insn_ready_i,
  output logic [CW-1:0]     insn_count_o,
  output logic [DW-1:0]     insn_payload_o,
  output logic              insn_trunc_o,
  output logic              fmt_err_o
);
  localparam int IW = $clog2(NPAIR);

  parcel_t          sp_parcel [NPAIR];
  logic [NPAIR-1:0] sp_start;
  logic             sp_ok;
  parcel_t          buf_parcel [NPAIR];
  logic [NPAIR-1:0] buf_start;
  logic             buf_valid;
  logic [IW-1:0]    idx_q;
  logic             accept, step_ack;

  pair_splitter u_split (
    .w0_i(word0_i), .w1_i(word1_i),
    .parcel_o(sp_parcel), .start_o(sp_start), .ok_o(sp_ok)
  );

  assign pair_ready_o = !buf_valid;
  assign accept       = pair_valid_i && pair_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_valid <= 1'b0;
      idx_q     <= '0;
      buf_start <= '0;
      fmt_err_o <= 1'b0;
      for (int i = 0; i < NPAIR; i++) buf_parcel[i] <= '0;
    end else if (accept) begin
      if (sp_ok) begin
        buf_valid  <= 1'b1;
        idx_q      <= '0;
        buf_start  <= sp_start;
        buf_parcel <= sp_parcel;
      end else begin
        fmt_err_o <= 1'b1;
      end
    end else if (step_ack) begin
      if (idx_q == IW'(NPAIR-1)) buf_valid <= 1'b0;
      else idx_q <= idx_q + IW'(1);
    end
  end

  parcel_accum #(.MAX_PARCELS(MAX_PARCELS)) u_acc (
    .clk_i, .rst_ni,
    .step_vld_i(buf_valid),
    .parcel_i(buf_parcel[idx_q]),
    .start_i(buf_start[idx_q]),
    .step_ack_o(step_ack),
    .flush_req_i(flush_i && !buf_valid),
    .out_valid_o(insn_valid_o),
    .out_ready_i(insn_ready_i),
    .out_cnt_o(insn_count_o),
    .out_data_o(insn_payload_o),
    .out_trunc_o(insn_trunc_o)
  );

  AST_BAD_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !sp_ok |=> !buf_valid && fmt_err_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |=> fmt_err_o); // R8
  AST_GOOD_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && sp_ok |=> buf_valid && idx_q == '0); // R1
endmodule

// File: tb/parcel_pair_unpacker_test.sv
module parcel_pair_unpacker_test;
  localparam int MAXP = 6;
  localparam int PW   = 17;
  localparam int DW   = MAXP * PW;

  logic clk = 0, rst_ni = 0;
  logic pair_valid = 0, flush = 0, insn_ready = 0;
  logic [31:0] w0 = '0, w1 = '0;
  logic pair_ready, insn_valid, insn_trunc, fmt_err;
  logic [2:0] insn_count;
  logic [DW-1:0] insn_payload;

  int checks = 0, failures = 0, cyc = 0;
  int ready_pct = 70;

  parcel_pair_unpacker uut (
    .clk_i(clk), .rst_ni(rst_ni), .pair_valid_i(pair_valid), .pair_ready_o(pair_ready),
    .word0_i(w0), .word1_i(w1), .flush_i(flush), .insn_valid_o(insn_valid),
    .insn_ready_i(insn_ready), .insn_count_o(insn_count), .insn_payload_o(insn_payload),
    .insn_trunc_o(insn_trunc), .fmt_err_o(fmt_err)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference model
  int            m_cnt = 0;
  logic [DW-1:0] m_data = '0;
  bit            m_trunc = 0;
  logic [2:0]    q_cnt [$];
  logic [DW-1:0] q_data [$];
  bit            q_trunc [$];

  task automatic m_push();
    q_cnt.push_back(3'(m_cnt)); q_data.push_back(m_data); q_trunc.push_back(m_trunc);
  endtask

  task automatic m_parcel(input bit s, input logic [16:0] p);
    if (s) begin
      if (m_cnt > 0) m_push();
      m_cnt = 1; m_trunc = 0;
      m_data = '0; m_data[DW-1 -: PW] = p;
    end else if (m_cnt == 0) begin
    end else if (m_cnt < MAXP) begin
      m_data[DW-1-m_cnt*PW -: PW] = p;
      m_cnt++;
    end else m_trunc = 1;
  endtask

  task automatic send(input bit s0, s1, s2, input logic [16:0] a, b, c, input bit bad);
    logic [31:0] x0, x1;
    bit hs;
    x0 = {5'b11110, s0, s1, a, b[16:9]};
    x1 = {5'b11111, s2, b[8:0], c};
    if (bad) begin
      if ($urandom_range(0, 1) == 0) x0[31] = 1'b0;
      else x1[27] = 1'b0;
    end else begin
      m_parcel(s0, a); m_parcel(s1, b); m_parcel(s2, c);
    end
    @(negedge clk);
    w0 = x0; w1 = x1; pair_valid = 1;
    hs = 0;
    while (!hs) begin
      hs = pair_ready;
      @(negedge clk);
    end
    pair_valid = 0;
  endtask

  task automatic close_group(input string tag);
    if (m_cnt > 0) begin m_push(); m_cnt = 0; m_trunc = 0; m_data = '0; end
    @(negedge clk);
    flush = 1;
    for (int i = 0; i < 300 && q_cnt.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    flush = 0;
    chk(q_cnt.size() == 0, {tag, " all expected instructions delivered"}, q_cnt.size(), 0);
  endtask

  // output ready, changed away from edges
  always @(posedge clk) begin
    #1 insn_ready <= ($urandom_range(0, 99) < ready_pct);
  end

  // monitor
  bit hold_prev = 0;
  logic [2:0] h_cnt; logic [DW-1:0] h_data; bit h_trunc;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (hold_prev)
        chk(insn_valid && insn_count == h_cnt && insn_payload == h_data && insn_trunc == h_trunc,
            "R9 output held while stalled", {insn_valid, insn_count}, {1'b1, h_cnt});
      hold_prev = insn_valid && !insn_ready;
      h_cnt = insn_count; h_data = insn_payload; h_trunc = insn_trunc;
      if (insn_valid && insn_ready) begin
        if (q_cnt.size() == 0) chk(0, "R3 R6 unexpected instruction", insn_count, 0);
        else begin
          chk(insn_count == q_cnt[0], "R3 R4 parcel count", insn_count, q_cnt[0]);
          chk(insn_payload == q_data[0], "R1 R2 payload", insn_payload, q_data[0]);
          chk(insn_trunc == q_trunc[0], "R7 truncation flag", insn_trunc, q_trunc[0]);
          void'(q_cnt.pop_front()); void'(q_data.pop_front()); void'(q_trunc.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!insn_valid && pair_ready && !fmt_err, "R10 state in reset", {insn_valid, pair_ready, fmt_err}, 3'b010);
    rst_ni = 1;
    @(negedge clk);
    chk(!insn_valid && pair_ready && !fmt_err, "R10 state after reset", {insn_valid, pair_ready, fmt_err}, 3'b010);

    // R3: three single-parcel instructions in one pair
    send(1, 1, 1, 17'h1abcd, 17'h0f0f1, 17'h15555, 0);
    close_group("R3");
    // R4 R2: one instruction spanning two pairs (5 parcels)
    send(0, 1, 0, 17'h00001, 17'h1ffff, 17'h12345, 0);
    send(0, 0, 0, 17'h0aaaa, 17'h15555, 17'h00111, 0);
    close_group("R4");
    // R5: flush with nothing open
    @(negedge clk); flush = 1; repeat (8) @(negedge clk); flush = 0;
    chk(!insn_valid && q_cnt.size() == 0, "R5 flush with nothing open emits nothing", insn_valid, 0);
    // R6: orphan continuation parcels
    send(0, 0, 1, 17'h11111, 17'h02222, 17'h03333, 0);
    close_group("R6");
    // R7: exactly six, then seven-plus parcels
    send(1, 0, 0, 17'h00006, 17'h00005, 17'h00004, 0);
    send(0, 0, 0, 17'h00003, 17'h00002, 17'h00001, 0);
    send(1, 0, 0, 17'h1000a, 17'h1000b, 17'h1000c, 0);
    send(0, 0, 0, 17'h1000d, 17'h1000e, 17'h1000f, 0);
    send(0, 0, 1, 17'h10010, 17'h10011, 17'h10012, 0);
    close_group("R7");
    // R8: broken prefix drops pair, flag sticky, open instruction untouched
    chk(!fmt_err, "R8 error flag clear before bad pair", fmt_err, 0);
    send(1, 0, 1, 17'h0abcd, 17'h0beef, 17'h0cafe, 0);
    send(1, 1, 1, 17'h1dead, 17'h1dead, 17'h1dead, 1);
    send(0, 1, 0, 17'h00777, 17'h00888, 17'h00999, 0);
    repeat (3) @(negedge clk);
    chk(fmt_err, "R8 error flag set after bad pair", fmt_err, 1);
    close_group("R8");
    chk(fmt_err, "R8 error flag still set", fmt_err, 1);

    // random groups
    for (int g = 0; g < 150; g++) begin
      int n;
      ready_pct = $urandom_range(20, 100);
      n = $urandom_range(1, 5);
      for (int k = 0; k < n; k++)
        send($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
             17'($urandom), 17'($urandom), 17'($urandom), $urandom_range(0, 15) == 0);
      close_group("R3 R4 R5 random");
    end
    chk(fmt_err, "R8 error flag sticky at end", fmt_err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule